// File: doc/BRIEF.md
# Parallel-Lane 3x3 Window Generator with Sobel Kernel

This block forms 3x3 pixel neighbourhoods for a video stream that carries P horizontally adjacent 8-bit pixels per beat, where P is a build-time parameter (2 or 4). Every storage element holds one whole group of P pixels. Line storage is a shift chain of groups two rows plus three groups long. A register window of three rows by three groups is read from taps on that chain. In each step P overlapping neighbourhoods are cut from that window, one centred on each lane of the current group. Each is handed to its own copy of the kernel. The example kernel is a Sobel gradient magnitude. One output group of P result pixels leaves the block for every input group.

The frame size is fixed by the parameters WIDTH (in pixels, a multiple of P) and HEIGHT (in rows). At every frame edge, a missing neighbour takes the value of the nearest pixel inside the image. The result for a row needs the row below it. So after the last group of a frame, the block spends G+2 steps (G = WIDTH/P) draining itself, and does not accept input during that time.

Both stream sides use valid/ready. An input beat is taken on a clock edge where in_valid and in_ready are both high. An output beat is taken where out_valid and out_ready are both high. While an output beat waits (out_valid high, out_ready low), the whole pipeline freezes: out_data and the markers stay unchanged and in_ready is low. A cycle without an input beat outside the drain phase also leaves all state untouched. in_sof marks the first group of a frame. The output markers out_sof and out_eol travel with the results they describe.

Top module: `par_window_sobel`

## Requirements
- R1: Lane i of in_data and of out_data sits in bits [8*i+7:8*i] and carries image column g*P+i of group g. Groups arrive in row-major order. Exactly one output group is produced per input group, in the same order.
- R2: For an interior pixel, with the 3x3 neighbourhood indexed row-major from the top-left, the result is min(|Gx|+|Gy|, 255). Gx is the right column minus the left column, and Gy is the bottom row minus the top row, each with weights 1,2,1.
- R3: A neighbour outside the image (left of column 0, right of column WIDTH-1, above row 0, below row HEIGHT-1) is replaced by the nearest pixel inside the image.
- R4: Lane 0 takes its left neighbours from lane P-1 of the previous group. Lane P-1 takes its right neighbours from lane 0 of the next group.
- R5: With no stalls, out_valid first goes high on the (G+2)-th rising edge after the edge that accepts group 0 of a frame.
- R6: out_sof is high only with the first output group of a frame. out_eol is high exactly with the last group of each row (group index G-1 within the row).
- R7: While out_valid is high and out_ready is low, out_data, out_sof and out_eol keep their values, out_valid stays high and in_ready is low.
- R8: Gaps in in_valid (bubbles) change neither the results nor their order.
- R9: After the last group of a frame is accepted, in_ready stays low for exactly G+2 cycles (without output stalls) and is high again once the last result is out.
- R10: An accepted beat with in_sof high is taken as group 0 of a new frame, and a partly received earlier frame is dropped.
- R11: During and just after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input group present |
| in_ready | output | 1 | Block takes the input group on this edge |
| in_sof | input | 1 | Input group is the first of a frame |
| in_data | input | P*PIX_W | P input pixels, lane 0 lowest |
| out_valid | output | 1 | Output group present |
| out_ready | input | 1 | Sink takes the output group on this edge |
| out_sof | output | 1 | Output group is the first of a frame |
| out_eol | output | 1 | Output group is the last of a row |
| out_data | output | P*PIX_W | P result pixels, lane 0 lowest |

## Verification
The frames used are flat images, horizontal and vertical ramps, a diagonal ramp, a hard step placed on a group boundary, and a scrambled texture. Each frame is compared pixel by pixel with an independent neighbourhood model that clamps coordinates at the borders. A flat image must give zero everywhere. The two one-axis ramps each exercise one gradient direction alone and expose a swapped axis or wrong weights. Hand-computed probes on the first and last rows and columns show whether border replication is correct. The step, with its edge between the lanes of two groups, shows whether lanes take their neighbours from the adjacent group and whether the result saturates. The scrambled frame is run with input bubbles and output stalls together, which exposes any state that moves when it should hold. Latency, the drain window, marker placement and a frame restart by in_sof are checked with directed sequences.

// File: rtl/pws_pkg.sv
package pws_pkg;
  localparam int KDIM  = 3;
  localparam int KTAPS = KDIM * KDIM;

  // Row-major position of a neighbour in a flattened window.
  function automatic int tap(input int row, input int col);
    return row * KDIM + col;
  endfunction
endpackage

// File: rtl/pws_group_chain.sv
// Delay chain of pixel groups: two image rows plus three groups.
// Exposes, for each of three rows, the centre group and the edge pixels
// of the groups to its left and right.
module pws_group_chain import pws_pkg::*; #(
  parameter int P     = 4,
  parameter int PIX_W = 8,
  parameter int G     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic shift,
  input  logic [P-1:0][PIX_W-1:0] din,
  output logic [KDIM-1:0][P-1:0][PIX_W-1:0] row_c,
  output logic [KDIM-1:0][PIX_W-1:0] row_l,
  output logic [KDIM-1:0][PIX_W-1:0] row_r
);
  localparam int DEPTH = (KDIM - 1) * G + KDIM;

  logic [P-1:0][PIX_W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < DEPTH; s++) stage[s] <= '0;
    end else if (shift) begin
      stage[0] <= din;
      for (int s = 1; s < DEPTH; s++) stage[s] <= stage[s-1];
    end
  end

  // Row 0 is the oldest (top) row, row KDIM-1 the newest (bottom).
  for (genvar r = 0; r < KDIM; r++) begin : g_tap
    localparam int B = (KDIM - 1 - r) * G;
    assign row_r[r] = stage[B][0];
    assign row_c[r] = stage[B+1];
    assign row_l[r] = stage[B+2][P-1];
  end
endmodule

// File: rtl/pws_row_extend.sv
// Widens one row's centre group by one pixel on each side, replicating
// the edge pixel when the group touches the image border.
module pws_row_extend #(
  parameter int P     = 4,
  parameter int PIX_W = 8
) (
  input  logic first_col,
  input  logic last_col,
  input  logic [P-1:0][PIX_W-1:0] grp,
  input  logic [PIX_W-1:0] left_px,
  input  logic [PIX_W-1:0] right_px,
  output logic [P+1:0][PIX_W-1:0] ext
);
  assign ext[0]   = first_col ? grp[0]   : left_px;
  assign ext[P+1] = last_col  ? grp[P-1] : right_px;
  for (genvar i = 0; i < P; i++) begin : g_mid
    assign ext[i+1] = grp[i];
  end
endmodule

// File: rtl/pws_sobel_lane.sv
// One kernel instance: saturated Sobel gradient magnitude.
module pws_sobel_lane import pws_pkg::*; #(
  parameter int PIX_W = 8
) (
  input  logic [KTAPS-1:0][PIX_W-1:0] nb,
  output logic [PIX_W-1:0] mag
);
  localparam int SW = PIX_W + 3;
  localparam logic [SW-1:0] MAXV = SW'((1 << PIX_W) - 1);

  function automatic logic [SW-1:0] zx(input logic [PIX_W-1:0] v);
    return {3'b000, v};
  endfunction

  logic [SW-1:0] xp, xn, yp, yn, ax, ay, sum;
  logic signed [SW-1:0] gx, gy;

  always_comb begin
    xp = zx(nb[tap(0,2)]) + (zx(nb[tap(1,2)]) << 1) + zx(nb[tap(2,2)]);
    xn = zx(nb[tap(0,0)]) + (zx(nb[tap(1,0)]) << 1) + zx(nb[tap(2,0)]);
    yp = zx(nb[tap(2,0)]) + (zx(nb[tap(2,1)]) << 1) + zx(nb[tap(2,2)]);
    yn = zx(nb[tap(0,0)]) + (zx(nb[tap(0,1)]) << 1) + zx(nb[tap(0,2)]);
    gx = $signed(xp - xn);
    gy = $signed(yp - yn);
    ax = gx[SW-1] ? $unsigned(-gx) : $unsigned(gx);
    ay = gy[SW-1] ? $unsigned(-gy) : $unsigned(gy);
    sum = ax + ay;
    mag = (sum > MAXV) ? MAXV[PIX_W-1:0] : sum[PIX_W-1:0];
  end
endmodule

// File: rtl/par_window_sobel.sv
module par_window_sobel import pws_pkg::*; #(
  parameter int P      = 4,
  parameter int PIX_W  = 8,
  parameter int WIDTH  = 16,
  parameter int HEIGHT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_sof,
  input  logic [P*PIX_W-1:0] in_data,
  output logic out_valid,
  input  logic out_ready,
  output logic out_sof,
  output logic out_eol,
  output logic [P*PIX_W-1:0] out_data
);
  localparam int G    = WIDTH / P;
  localparam int N    = G * HEIGHT;
  localparam int LAST = N + G + 1;
  localparam int PCW  = $clog2(LAST + 1);
  localparam int CCW  = $clog2(G + 1);
  localparam int RCW  = $clog2(HEIGHT + 1);
  localparam logic [PCW-1:0] N_C    = PCW'(N);
  localparam logic [PCW-1:0] LAST_C = PCW'(LAST);
  localparam logic [PCW-1:0] FILL_C = PCW'(G + 2);
  localparam logic [CCW-1:0] GL_C   = CCW'(G - 1);
  localparam logic [RCW-1:0] HL_C   = RCW'(HEIGHT - 1);

  // Groups pushed into the chain in this frame; the window centre lags by G+2.
  logic [PCW-1:0] pushed;
  logic [CCW-1:0] ccol;
  logic [RCW-1:0] crow;
  logic hold, draining, step, restart, cap_valid, last_step;
  logic first_col, last_col, first_row, last_row;

  assign hold      = out_valid & ~out_ready;
  assign draining  = (pushed >= N_C);
  assign in_ready  = ~hold & ~draining;
  assign step      = ~hold & (draining | in_valid);
  assign restart   = in_valid & in_ready & in_sof;
  assign cap_valid = (pushed >= FILL_C);
  assign last_step = (pushed == LAST_C);
  assign first_col = (ccol == '0);
  assign last_col  = (ccol == GL_C);
  assign first_row = (crow == '0);
  assign last_row  = (crow == HL_C);

  logic [P-1:0][PIX_W-1:0] din;
  assign din = draining ? '0 : in_data;

  logic [KDIM-1:0][P-1:0][PIX_W-1:0] tap_c, sel_c;
  logic [KDIM-1:0][PIX_W-1:0] tap_l, tap_r, sel_l, sel_r;

  pws_group_chain #(.P(P), .PIX_W(PIX_W), .G(G)) u_chain (
    .clk(clk), .rst(rst), .shift(step), .din(din),
    .row_c(tap_c), .row_l(tap_l), .row_r(tap_r)
  );

  // Vertical replication: top and bottom rows fall back to the centre row.
  always_comb begin
    sel_c[1] = tap_c[1];
    sel_l[1] = tap_l[1];
    sel_r[1] = tap_r[1];
    sel_c[0] = first_row ? tap_c[1] : tap_c[0];
    sel_l[0] = first_row ? tap_l[1] : tap_l[0];
    sel_r[0] = first_row ? tap_r[1] : tap_r[0];
    sel_c[2] = last_row  ? tap_c[1] : tap_c[2];
    sel_l[2] = last_row  ? tap_l[1] : tap_l[2];
    sel_r[2] = last_row  ? tap_r[1] : tap_r[2];
  end

  logic [KDIM-1:0][P+1:0][PIX_W-1:0] ext;

  for (genvar r = 0; r < KDIM; r++) begin : g_row
    pws_row_extend #(.P(P), .PIX_W(PIX_W)) u_ext (
      .first_col(first_col), .last_col(last_col),
      .grp(sel_c[r]), .left_px(sel_l[r]), .right_px(sel_r[r]),
      .ext(ext[r])
    );
  end

  logic [P-1:0][PIX_W-1:0] lane_mag;

  for (genvar i = 0; i < P; i++) begin : g_lane
    logic [KTAPS-1:0][PIX_W-1:0] nb;
    for (genvar r = 0; r < KDIM; r++) begin : g_nr
      for (genvar k = 0; k < KDIM; k++) begin : g_nk
        assign nb[r*KDIM + k] = ext[r][i+k];
      end
    end
    pws_sobel_lane #(.PIX_W(PIX_W)) u_kernel (.nb(nb), .mag(lane_mag[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pushed    <= '0;
      ccol      <= '0;
      crow      <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_data  <= '0;
    end else if (step) begin
      if (restart) begin
        pushed    <= PCW'(1);
        ccol      <= '0;
        crow      <= '0;
        out_valid <= 1'b0;
        out_sof   <= 1'b0;
        out_eol   <= 1'b0;
      end else begin
        pushed    <= last_step ? '0 : pushed + PCW'(1);
        out_valid <= cap_valid;
        out_sof   <= cap_valid & first_row & first_col;
        out_eol   <= cap_valid & last_col;
        if (cap_valid) begin
          out_data <= lane_mag;
          if (last_col) begin
            ccol <= '0;
            crow <= last_row ? '0 : crow + RCW'(1);
          end else begin
            ccol <= ccol + CCW'(1);
          end
        end
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end
  end
endmodule

// File: rtl/pws_checker.sv
module pws_checker #(
  parameter int P      = 4,
  parameter int PIX_W  = 8,
  parameter int WIDTH  = 16,
  parameter int HEIGHT = 6
) (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_sof,
  input logic out_eol,
  input logic [P*PIX_W-1:0] out_data
);
  localparam int G  = WIDTH / P;
  localparam int N  = G * HEIGHT;
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] ocount, idx_cur;
  int idx_i;
  assign idx_cur = out_sof ? '0 : ocount;
  assign idx_i   = int'(idx_cur);

  always_ff @(posedge clk) begin
    if (rst) ocount <= '0;
    else if (out_valid && out_ready) ocount <= idx_cur + CW'(1);
  end

  p_hold_output_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eol)));

  p_no_intake_on_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_sof_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);

  p_eol_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    out_eol |-> out_valid);

  p_eol_position_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_eol == ((idx_i % G) == G - 1)));

  p_frame_length_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sof) |-> (idx_i != 0 && idx_i < N));

  p_reset_idle_r11: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind par_window_sobel pws_checker #(
  .P(P), .PIX_W(PIX_W), .WIDTH(WIDTH), .HEIGHT(HEIGHT)
) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_sof(out_sof), .out_eol(out_eol), .out_data(out_data)
);

// File: tb/sim_par_window_sobel.sv
module sim_par_window_sobel;
  localparam int P = 4;
  localparam int W = 16;
  localparam int H = 6;
  localparam int G = W / P;
  localparam int N = G * H;
  localparam int NT = 11;
  // kind, k1, mode(bit0 input bubbles, bit1 output stalls), probe row, probe col, probe value, requirement
  localparam int TAB [0:NT-1][0:6] = '{
    '{0, 77, 0, 2,  5,   0, 2},
    '{1, 10, 0, 2,  5,  80, 2},
    '{1, 10, 1, 3,  0,  40, 3},
    '{1, 10, 2, 1, 15,  40, 3},
    '{2, 20, 0, 2,  5, 160, 2},
    '{2, 20, 3, 0,  3,  80, 3},
    '{2, 20, 1, 5,  3,  80, 3},
    '{3,  0, 0, 2,  8, 255, 4},
    '{4,  5, 2, 2,  5,  80, 2},
    '{5,  3, 3, 0,  0,  -1, 8},
    '{3,  0, 0, 2,  7, 255, 4}
  };

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0, in_sof = 0, out_ready = 1;
  logic [P*8-1:0] in_data = '0;
  logic in_ready, out_valid, out_sof, out_eol;
  logic [P*8-1:0] out_data;

  int checks = 0, fails = 0;
  bit done = 0;
  int got [W*H];

  always #5 clk = ~clk;

  par_window_sobel #(.P(P), .PIX_W(8), .WIDTH(W), .HEIGHT(H)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_sof(out_sof), .out_eol(out_eol),
    .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pix(input int kind, input int k1, input int xi, input int yi);
    int x = (xi < 0) ? 0 : (xi > W-1) ? W-1 : xi;
    int y = (yi < 0) ? 0 : (yi > H-1) ? H-1 : yi;
    case (kind)
      0: return k1;
      1: return x * k1;
      2: return y * k1;
      3: return (x >= 8) ? 255 : 0;
      4: return (x + y) * k1;
      default: return (x * 37 + y * 91 + k1) & 255;
    endcase
  endfunction

  function automatic int ref_out(input int kind, input int k1, input int x, input int y);
    int gx, gy, s;
    gx = pix(kind,k1,x+1,y-1) + 2*pix(kind,k1,x+1,y) + pix(kind,k1,x+1,y+1)
       - pix(kind,k1,x-1,y-1) - 2*pix(kind,k1,x-1,y) - pix(kind,k1,x-1,y+1);
    gy = pix(kind,k1,x-1,y+1) + 2*pix(kind,k1,x,y+1) + pix(kind,k1,x+1,y+1)
       - pix(kind,k1,x-1,y-1) - 2*pix(kind,k1,x,y-1) - pix(kind,k1,x+1,y-1);
    s = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    return (s > 255) ? 255 : s;
  endfunction

  function automatic logic [P*8-1:0] pack_group(input int kind, input int k1, input int g);
    logic [P*8-1:0] v;
    int y = g / G;
    int xb = (g % G) * P;
    for (int i = 0; i < P; i++) v[i*8 +: 8] = 8'(pix(kind, k1, xb + i, y));
    return v;
  endfunction

  task automatic run_frame(input int kind, input int k1, input int mode, input int pr,
                           input int pc, input int pexp, input int req);
    int bi = 0, oi = 0, it = 0, first_in = -1, first_out = -1, drain_low = 0;
    int mism = 0, bad_x = 0, bad_act = 0, bad_exp = 0, mark_err = 0, hold_err = 0;
    bit ready_after = 0, prev_hold = 0;
    logic [P*8-1:0] prev_data = '0;
    while (oi < N && it < 5000) begin
      in_valid  = (bi < N) && !(mode[0] && (it % 4 == 1));
      in_sof    = (bi == 0);
      in_data   = (bi < N) ? pack_group(kind, k1, bi) : '0;
      out_ready = !(mode[1] && (it % 3 == 0));
      #1;
      if (prev_hold && !(out_valid && out_data == prev_data)) hold_err++;
      if (out_valid && !out_ready && in_ready) hold_err++;
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      if (in_valid && in_ready) begin
        if (bi == 0) first_in = it;
        bi++;
      end else if (bi == N && !in_ready) begin
        drain_low++;
      end
      if (out_valid && out_ready) begin
        if (oi == 0) first_out = it;
        if (out_sof != (oi == 0)) mark_err++;
        if (out_eol != (oi % G == G - 1)) mark_err++;
        for (int i = 0; i < P; i++) begin
          int x = (oi % G) * P + i;
          int y = oi / G;
          int e = ref_out(kind, k1, x, y);
          got[y*W + x] = int'(out_data[i*8 +: 8]);
          if (got[y*W + x] != e) begin
            if (mism == 0) begin bad_x = y*W + x; bad_act = got[y*W + x]; bad_exp = e; end
            mism++;
          end
        end
        oi++;
        if (oi == N) ready_after = in_ready;
      end
      @(negedge clk);
      it++;
    end
    in_valid = 0; in_sof = 0; out_ready = 1;
    check(oi == N, "R1", oi, N, "output group count");
    check(mism == 0, $sformatf("R%0d", req), bad_act, bad_exp,
          $sformatf("pixel mismatch at index %0d (%0d wrong)", bad_x, mism));
    check(mark_err == 0, "R6", mark_err, 0, "sof/eol marker errors");
    if (pexp >= 0)
      check(got[pr*W + pc] == pexp, $sformatf("R%0d", req), got[pr*W + pc], pexp,
            $sformatf("probe row %0d col %0d", pr, pc));
    if (mode[1]) check(hold_err == 0, "R7", hold_err, 0, "output changed or input taken while held");
    if (mode[0]) check(mism == 0, "R8", mism, 0, "bubbled frame mismatches");
    if (mode == 0) begin
      check(first_out - first_in == G + 3, "R5", first_out - first_in, G + 3, "first output sample offset");
      check(drain_low == G + 2, "R9", drain_low, G + 2, "cycles with in_ready low while draining");
      check(ready_after == 1'b1, "R9", int'(ready_after), 1, "in_ready after last output");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R11", int'(out_valid), 0, "out_valid in reset");
    check(in_ready == 1'b1, "R11", int'(in_ready), 1, "in_ready in reset");
    rst = 0;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R11", int'(out_valid), 0, "out_valid after reset");
    check(in_ready == 1'b1, "R11", int'(in_ready), 1, "in_ready after reset");
    @(negedge clk);

    // Table of frames: R1 R2 R3 R4 R8 and, where stalled, R7.
    for (int t = 0; t < NT; t++)
      run_frame(TAB[t][0], TAB[t][1], TAB[t][2], TAB[t][3], TAB[t][4], TAB[t][5], TAB[t][6]);

    // R10: partial frame then restart with in_sof.
    seen = 0;
    for (int b = 0; b < 3; b++) begin
      in_valid = 1; in_sof = (b == 0); in_data = pack_group(5, 99, b);
      #1; if (out_valid) seen++;
      @(negedge clk);
    end
    in_valid = 0; in_sof = 0;
    #1; if (out_valid) seen++;
    check(seen == 0, "R10", seen, 0, "outputs from aborted frame");
    @(negedge clk);
    run_frame(1, 10, 0, 2, 5, 80, 10);

    // R6 over stalls with a different ramp, and back-to-back frames.
    run_frame(4, 5, 3, 0, 15, 40, 6);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule